// File: doc/BRIEF.md
# Seconds Counter with Alarm and Tick Events

This block is a memory-mapped real-time clock. A slow reference-clock enable (nominally 32.768 kHz, one pulse per reference period) drives a programmable prescaler. The prescaler produces a once-per-second tick that advances a 32-bit seconds counter. Software reads and writes four 32-bit registers over a simple single-cycle register bus: the seconds count, an alarm compare value, a divider/trim setting and a combined event status/enable register.

Two sticky events are kept. The first is the tick event and the second is the alarm match. Each event has its own enable bit and drives its own interrupt line. An event flag may already be set when the block leaves reset. Its interrupt line stays low until software sets the matching enable bit. A flag is cleared by writing a one to its bit. Because the enables sit in the same register, software can clear a flag and keep or change the enables in a single write.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the counter and alarm read 0, the divider/trim register reads 32767 (0x7FFF), and both enables are clear. The status register reads 0x2: the tick flag comes up set (parameter `RST_FLAGS`) and the alarm flag comes up clear.
- R2: Status bit 3 is the tick enable and bit 2 is the alarm enable. Both take the written value directly. Bit 1 is the tick flag and bit 0 is the alarm flag. A flag is cleared by writing 1 to its bit, and writing 0 leaves it unchanged. Bits 31..4 read 0.
- R3: If a flag is set and cleared by a write in the same cycle, the flag ends up set.
- R4: The divider sits in bits 15..0 of the divider/trim register. A tick occurs once every divider+1 reference enables. A divider of 0 is treated as 32767, and the register still reads back the written value.
- R5: The counter can be written by software. It advances by one on each tick and wraps from 0xFFFFFFFF to 0.
- R6: The alarm flag is set on the tick whose new counter value equals the alarm register.
- R7: `irq_tick` is the tick flag ANDed with the tick enable, and `irq_alarm` is the alarm flag ANDed with the alarm enable. A flag that is set while its enable is clear raises no interrupt.
- R8: A counter write restarts the prescaler, so the next tick comes divider+1 enables after the write. A tick that would coincide with a counter write is dropped.
- R9: When the trim field (bits 31..16) is nonzero, every 1024th tick period is one enable longer. A write to the divider/trim register restarts both the prescaler and the 1024-tick epoch.
- R10: The default map places the counter at 0x0, the alarm at 0x4, the status at 0x8 and the divider/trim at 0xC. With `ALT_MAP=1` the alarm is at 0x00, the counter at 0x04, the divider/trim at 0x08 and the status at 0x10. Any other offset reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ce | input | 1 | Reference-clock enable, one pulse per 32.768 kHz period |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| irq_tick | output | 1 | Tick interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench checks the tick flag that is set at power-up while its enable is clear. A design that gated the flag wrongly would raise a spurious interrupt at start-up. The bench issues a write-one-to-clear in the same cycle as a tick; a design in which the clear won would lose that event. It also lands a counter write exactly where a tick was due. A design that did not restart the prescaler on that write would tick early or count twice. The remaining checks cover counter wrap into an alarm value of 0, a divider of zero, the one-enable lengthening of the 1024th trimmed period, and accesses to unmapped offsets.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_ALARM  = 2'd1,
    REG_STATUS = 2'd2,
    REG_DIVTRM = 2'd3
  } reg_id_e;

  typedef struct packed {
    logic    hit;
    reg_id_e id;
  } reg_sel_t;

  // status register bit positions (software decodes these)
  localparam int unsigned ST_TICK_EN  = 3;
  localparam int unsigned ST_ALARM_EN = 2;
  localparam int unsigned ST_TICK_FL  = 1;
  localparam int unsigned ST_ALARM_FL = 0;

  // Byte offset to register, for either map.
  function automatic reg_sel_t decode_addr(input logic [7:0] a, input bit alt);
    reg_sel_t s;
    s.hit = 1'b1;
    s.id  = REG_COUNT;
    if (!alt) begin
      case (a)
        8'h00:   s.id = REG_COUNT;
        8'h04:   s.id = REG_ALARM;
        8'h08:   s.id = REG_STATUS;
        8'h0C:   s.id = REG_DIVTRM;
        default: s.hit = 1'b0;
      endcase
    end else begin
      case (a)
        8'h00:   s.id = REG_ALARM;
        8'h04:   s.id = REG_COUNT;
        8'h08:   s.id = REG_DIVTRM;
        8'h10:   s.id = REG_STATUS;
        default: s.hit = 1'b0;
      endcase
    end
    return s;
  endfunction

  // Effective divider: zero falls back to the default.
  function automatic logic [15:0] eff_divider(input logic [15:0] d, input logic [15:0] dflt);
    return (d == '0) ? dflt : d;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned TRIM_PERIOD = 1024,
  parameter int unsigned DEF_DIV     = 32767
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             restart,
  input  logic             epoch_clr,
  input  logic [DIV_W-1:0] div_field,
  input  logic             trim_on,
  output logic             tick
);
  import rtc_sec_pkg::*;

  localparam int unsigned PW = DIV_W + 1;
  localparam int unsigned EW = (TRIM_PERIOD > 1) ? $clog2(TRIM_PERIOD) : 1;

  logic [PW-1:0] phase;
  logic [EW-1:0] epoch;
  logic [PW-1:0] limit;
  logic          extra;
  logic          at_limit;

  assign extra    = trim_on && (epoch == EW'(TRIM_PERIOD - 1));
  assign limit    = {1'b0, DIV_W'(eff_divider(16'(div_field), 16'(DEF_DIV)))} + PW'(extra);
  assign at_limit = (phase == limit);
  assign tick     = ce && at_limit && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      phase <= '0;
    else if (ce)
      phase <= at_limit ? '0 : phase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || epoch_clr)
      epoch <= '0;
    else if (tick)
      epoch <= (epoch == EW'(TRIM_PERIOD - 1)) ? '0 : epoch + 1'b1;
  end

  // R4: ticks can never come back to back (divider is at least 1)
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R8: the cycle after a restart never ticks
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic         alm_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] alarm,
  output logic         alarm_hit
);

  logic [W-1:0] next_count;

  assign next_count = count + 1'b1;
  assign alarm_hit  = tick && (next_count == alarm);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (cnt_we) count <= wdata;
    else if (tick)   count <= next_count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      alarm <= '0;
    else if (alm_we) alarm <= wdata;
  end

  // R5: a tick advances the count by one (with wrap)
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we) |=> (count == $past(count) + 1'b1));
  // R5: a software write loads the count
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(wdata)));

endmodule

// File: rtl/rtc_event_status.sv
module rtc_event_status #(
  parameter logic [1:0] RST_FLAGS = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       alarm_hit,
  input  logic       sts_we,
  input  logic [3:0] wbits,
  output logic [3:0] status,
  output logic       irq_tick,
  output logic       irq_alarm
);
  import rtc_sec_pkg::*;

  logic tick_en, alarm_en, tick_fl, alarm_fl;
  logic clr_tick, clr_alarm;

  assign clr_tick  = sts_we && wbits[ST_TICK_FL];
  assign clr_alarm = sts_we && wbits[ST_ALARM_FL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_en  <= 1'b0;
      alarm_en <= 1'b0;
    end else if (sts_we) begin
      tick_en  <= wbits[ST_TICK_EN];
      alarm_en <= wbits[ST_ALARM_EN];
    end
  end

  // set has priority over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_fl  <= RST_FLAGS[1];
      alarm_fl <= RST_FLAGS[0];
    end else begin
      tick_fl  <= tick      | (tick_fl  & ~clr_tick);
      alarm_fl <= alarm_hit | (alarm_fl & ~clr_alarm);
    end
  end

  assign status    = {tick_en, alarm_en, tick_fl, alarm_fl};
  assign irq_tick  = tick_fl & tick_en;
  assign irq_alarm = alarm_fl & alarm_en;

  // R3: a tick always leaves the tick flag set, clear or not
  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> status[ST_TICK_FL]);
  // R6: an alarm match leaves the alarm flag set
  a_r6_alarm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> status[ST_ALARM_FL]);
  // R2: writing 0 to a set flag keeps it
  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we && !wbits[ST_ALARM_FL] && status[ST_ALARM_FL]) |=> status[ST_ALARM_FL]);
  // R7: an interrupt only rises after a tick or a status write
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tick) |-> ($past(tick) || $past(sts_we)));

endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm #(
  parameter bit          ALT_MAP     = 1'b0,
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 32,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned TRIM_PERIOD = 1024,
  parameter int unsigned DEF_DIV     = 32767,
  parameter logic [1:0]  RST_FLAGS   = 2'b10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_ce,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_tick,
  output logic          irq_alarm
);
  import rtc_sec_pkg::*;

  localparam int unsigned TRIM_W = DW - DIV_W;

  reg_sel_t      sel;
  logic          wr_hit;
  logic          cnt_we, alm_we, sts_we, trm_we;
  logic          tick, alarm_hit;
  logic [DW-1:0] count, alarm, divtrm;
  logic [3:0]    status;

  assign sel    = decode_addr(8'(bus_addr), ALT_MAP);
  assign wr_hit = bus_sel && bus_wr && sel.hit;
  assign cnt_we = wr_hit && (sel.id == REG_COUNT);
  assign alm_we = wr_hit && (sel.id == REG_ALARM);
  assign sts_we = wr_hit && (sel.id == REG_STATUS);
  assign trm_we = wr_hit && (sel.id == REG_DIVTRM);

  always_ff @(posedge clk) begin
    if (!rst_n)      divtrm <= DW'(DEF_DIV);
    else if (trm_we) divtrm <= bus_wdata;
  end

  rtc_prescaler #(
    .DIV_W(DIV_W), .TRIM_PERIOD(TRIM_PERIOD), .DEF_DIV(DEF_DIV)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .ce(ref_ce),
    .restart(cnt_we || trm_we), .epoch_clr(trm_we),
    .div_field(divtrm[DIV_W-1:0]),
    .trim_on(|divtrm[DW-1 -: TRIM_W]),
    .tick(tick)
  );

  rtc_sec_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_we(cnt_we), .alm_we(alm_we), .wdata(bus_wdata),
    .count(count), .alarm(alarm), .alarm_hit(alarm_hit)
  );

  rtc_event_status #(.RST_FLAGS(RST_FLAGS)) u_sts (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_hit(alarm_hit),
    .sts_we(sts_we), .wbits(bus_wdata[3:0]),
    .status(status), .irq_tick(irq_tick), .irq_alarm(irq_alarm)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel.hit) begin
      case (sel.id)
        REG_COUNT:  bus_rdata = count;
        REG_ALARM:  bus_rdata = alarm;
        REG_STATUS: bus_rdata = DW'(status);
        REG_DIVTRM: bus_rdata = divtrm;
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R10: no register changes on a write to an unmapped offset
  a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !sel.hit) |=> $stable(divtrm) && $stable(alarm));

endmodule

// File: tb/sim_rtc_sec_alarm.sv
`timescale 1ns/1ps
module sim_rtc_sec_alarm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_ce = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic        irq_t0, irq_a0, irq_t1, irq_a1;
  logic        mon_req = 1'b0;
  logic        mon_alt = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  rtc_sec_alarm u0 (
    .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
    .irq_tick(irq_t0), .irq_alarm(irq_a0)
  );

  rtc_sec_alarm #(.ALT_MAP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ref_ce(ref_ce), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
    .irq_tick(irq_t1), .irq_alarm(irq_a1)
  );

  // scoreboard monitor: samples mid-cycle after each read request
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (mon_req && exp_q.size() > 0) begin
        logic [31:0] e, act;
        string t;
        e   = exp_q.pop_front();
        t   = tag_q.pop_front();
        act = mon_alt ? rdata1 : rdata0;
        n_cmp++;
        if (act !== e) begin
          n_bad++;
          $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", t, bus_addr, act, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit with_ce = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    ref_ce = with_ce; mon_req = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t, input bit alt = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; ref_ce = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    mon_alt = alt; mon_req = 1'b1;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; ref_ce = 1'b1; mon_req = 1'b0;
    end
    @(negedge clk);
    ref_ce = 1'b0;
  endtask

  task automatic chk_irq(input logic et, input logic ea, input string t);
    @(negedge clk);
    bus_sel = 1'b0; ref_ce = 1'b0; mon_req = 1'b0;
    #1;
    n_cmp++;
    if (irq_t0 !== et || irq_a0 !== ea) begin
      n_bad++;
      $display("FAIL %s: irq tick/alarm got %b%b expected %b%b", t, irq_t0, irq_a0, et, ea);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R7 power-up flag without interrupt
    rd(8'h00, 32'd0, "R1 count");
    rd(8'h04, 32'd0, "R1 alarm");
    rd(8'h08, 32'h2, "R1 status power-up flag");
    rd(8'h0C, 32'd32767, "R1 divtrm");
    chk_irq(1'b0, 1'b0, "R7 power-up flag gated");
    // R10 alternate map on u1, unmapped on both
    rd(8'h08, 32'd32767, "R10 alt divtrm", 1'b1);
    rd(8'h10, 32'h2, "R10 alt status", 1'b1);
    rd(8'h0C, 32'd0, "R10 alt unmapped", 1'b1);
    rd(8'h10, 32'd0, "R10 default unmapped");
    // R4 divider 3 -> 4 enables per tick
    wr(8'h0C, 32'd3);
    wr(8'h00, 32'd10);
    pulse(3); rd(8'h00, 32'd10, "R4 before period end");
    pulse(1); rd(8'h00, 32'd11, "R4 R5 one tick");
    // R2 clear flags
    wr(8'h08, 32'h3); rd(8'h08, 32'h0, "R2 w1c both");
    pulse(4); rd(8'h00, 32'd12, "R5 advance");
    rd(8'h08, 32'h2, "R7 flag set enable clear");
    chk_irq(1'b0, 1'b0, "R7 no irq while disabled");
    wr(8'h08, 32'h8); rd(8'h08, 32'hA, "R2 zero keeps flag");
    chk_irq(1'b1, 1'b0, "R7 tick irq");
    wr(8'h08, 32'hA); rd(8'h08, 32'h8, "R2 one clears flag");
    chk_irq(1'b0, 1'b0, "R7 tick irq cleared");
    // R6 alarm
    wr(8'h04, 32'd14); wr(8'h08, 32'h4);
    pulse(4); rd(8'h08, 32'h6, "R6 no match at 13");
    chk_irq(1'b0, 1'b0, "R7 tick disabled");
    pulse(4); rd(8'h08, 32'h7, "R6 match at 14");
    chk_irq(1'b0, 1'b1, "R6 R7 alarm irq");
    // R3 set beats clear
    wr(8'h08, 32'h7); rd(8'h08, 32'h4, "R2 clear both");
    pulse(3); wr(8'h08, 32'h6, 1'b1);
    rd(8'h08, 32'h6, "R3 set wins");
    rd(8'h00, 32'd15, "R3 tick counted");
    // R8 restart on counter write
    pulse(2); wr(8'h00, 32'd100);
    pulse(3); rd(8'h00, 32'd100, "R8 restarted phase");
    pulse(1); rd(8'h00, 32'd101, "R8 full period after write");
    pulse(3); wr(8'h00, 32'd200, 1'b1);
    rd(8'h00, 32'd200, "R8 coinciding tick dropped");
    pulse(3); rd(8'h00, 32'd200, "R8 no early tick");
    pulse(1); rd(8'h00, 32'd201, "R8 tick after restart");
    // R5 wrap into alarm 0
    wr(8'h04, 32'd0); wr(8'h00, 32'hFFFF_FFFF); wr(8'h08, 32'h7);
    pulse(4); rd(8'h00, 32'd0, "R5 wrap");
    rd(8'h08, 32'h7, "R6 match after wrap");
    // R10 unmapped write ignored
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h00, 32'd0, "R10 count kept");
    rd(8'h04, 32'd0, "R10 alarm kept");
    rd(8'h08, 32'h7, "R10 status kept");
    rd(8'h0C, 32'd3, "R10 divtrm kept");
    // R4 divider zero behaves as 32767
    wr(8'h0C, 32'd0); rd(8'h0C, 32'd0, "R4 raw readback");
    wr(8'h00, 32'd0);
    pulse(32767); rd(8'h00, 32'd0, "R4 zero divider long period");
    pulse(1); rd(8'h00, 32'd1, "R4 zero divider tick");
    // R9 trim lengthens the 1024th period
    wr(8'h00, 32'd0); wr(8'h0C, 32'h0001_0003);
    pulse(1023 * 4); rd(8'h00, 32'd1023, "R9 normal periods");
    pulse(4); rd(8'h00, 32'd1023, "R9 extended period not done");
    pulse(1); rd(8'h00, 32'd1024, "R9 extended period end");
    pulse(4); rd(8'h00, 32'd1025, "R9 normal again");
    @(negedge clk); bus_sel = 1'b0; mon_req = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule